// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates the seven interrupt sources of a small 8-bit microcontroller core. The sources are two external pins, three timers, a serial port and a capture/compare array. It combines the raw request flags with a per-source enable mask and a global enable. It also takes two priority registers that give every source one of four levels, and it compares the result against a four-level in-service stack. From this it raises a request to the core and presents the 24-bit vector of the winning source.

The request and the take strobe form a valid/ready pair. `irq_req` is valid, and `irq_take` is ready from the core. A vector is transferred only on a cycle where both are high. The core may hold `irq_take` low for as long as it likes. The request and vector keep following the source flags and the registers, so the core latches `irq_vec` on the take cycle. On a transfer, the block marks the winner's level as in service. It also clears an edge-mode pin flag and pulses a one-hot acknowledge one cycle later, so that the owner of a hardware-cleared flag can drop it. A return strobe from the core retires the highest level in service.

The external pins are active low and pass through a two-stage synchronizer. Each pin works either as a falling-edge detector with a latched flag, or as a level request that tracks the pin.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_ack` is 0 and `lvl_active` is 0.
- R2: With `ie_reg[7]` (global enable) at 0, `irq_req` stays 0 whatever the requests are.
- R3: A source whose own enable bit is 0 never produces a request. The enable bits are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 array.
- R4: Each source's level is {`iph_reg[n]`, `ipl_reg[n]`}, using the same bit index n as its enable bit, and 3 is the highest level. A pending source at a higher level beats any source at a lower level.
- R5: Among pending sources at the same level, the lowest bit index wins.
- R6: `irq_vec` for the winner is 24'hFF0003 + 8 × index: FF0003, FF000B, FF0013, FF001B, FF0023, FF002B and FF0033 for indices 0 to 6.
- R7: On a cycle with `irq_req` and `irq_take` both high, the winner's level bit in `lvl_active` is set at that edge. In the next cycle, `irq_ack` carries exactly the winner's one-hot bit, and it is 0 in the cycle after that.
- R8: A request is forwarded only if its level is strictly above the highest level in `lvl_active`.
- R9: A pulse on `irq_ret` clears the highest set bit of `lvl_active`.
- R10: In edge mode (`ext_edge_mode[k]`=1), a falling edge on the pin latches a request. The take clears it, and a pin that stays low does not raise it again.
- R11: In level mode, the pin request is present while the synchronized pin is low. A take does not clear it.
- R12: The timer 2 request is `tmr2_ovf` OR `tmr2_ext`, the serial request is `ser_rx` OR `ser_tx`, and the array request is `arr_cnt` OR any `arr_mod` bit. None of these is cleared by the block. Timer 0 and timer 1 requests follow their input flags, and their owners clear them on `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External interrupt pins, active low |
| ext_edge_mode | input | 2 | 1 selects falling-edge detection, 0 selects level |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external flag |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| arr_cnt | input | 1 | Array counter flag |
| arr_mod | input | ARR_MODS (5) | Array module flags |
| ie_reg | input | 8 | Bit 7 global enable, bits 6..0 source enables |
| iph_reg | input | 8 | Priority high bits, bit 7 reserved |
| ipl_reg | input | 8 | Priority low bits, bit 7 reserved |
| irq_take | input | 1 | Core accepts the vector (ready) |
| irq_ret | input | 1 | Core returned from a service routine |
| irq_req | output | 1 | Request to the core (valid) |
| irq_vec | output | 24 | Vector address of the winner |
| irq_ack | output | 7 | One-cycle one-hot acknowledge of the taken source |
| lvl_active | output | 4 | In-service stack, one bit per level |

## Verification
The bench sets a lower-level source against a higher-level one that has a larger index. A design that ranked by index alone would vector to the wrong address. While a level is in service, it shows that an equal or lower level is held back and that a level-3 source gets through. A comparison written as greater-or-equal, or a return that cleared the lowest stack bit, would fail here. An edge-mode pin is held low after its take, to catch a detector that retriggers on level. A level-mode pin is shown to come back after the return, to catch a design that clears it on vectoring.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC    = 7;
  localparam int NUM_LVL    = 4;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int LVL_W      = $clog2(NUM_LVL);
  localparam int VEC_W      = 24;
  localparam logic [VEC_W-1:0] VEC_BASE = 24'hFF0003;
  localparam int VEC_STRIDE = 8;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [IDX_W-1:0] idx_t;

  function automatic logic [VEC_W-1:0] src_vector(idx_t idx);
    return VEC_BASE + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
  endfunction
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic edge_flag_q;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      edge_flag_q <= 1'b0;
    else if (fall)
      edge_flag_q <= 1'b1;
    else if (clr)
      edge_flag_q <= 1'b0;
  end

  assign flag = edge_mode ? edge_flag_q : ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] lvl_hi,
  input  logic [NUM_SRC-1:0] lvl_lo,
  input  logic               glob_en,
  input  logic [NUM_LVL-1:0] stack,
  output logic               req,
  output idx_t               win_idx,
  output lvl_t               win_lvl
);
  logic found;
  logic busy;
  lvl_t busy_lvl;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (!found || {lvl_hi[i], lvl_lo[i]} > win_lvl)) begin
        found   = 1'b1;
        win_idx = idx_t'(i);
        win_lvl = {lvl_hi[i], lvl_lo[i]};
      end
    end
  end

  always_comb begin
    busy     = 1'b0;
    busy_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (stack[l]) begin
        busy     = 1'b1;
        busy_lvl = lvl_t'(l);
      end
    end
  end

  assign req = glob_en & found & (!busy || (win_lvl > busy_lvl));
endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  lvl_t               push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] stack
);
  logic [NUM_LVL-1:0] nxt;

  always_comb begin
    nxt = stack;
    if (pop) begin
      for (int l = 0; l < NUM_LVL; l++)
        if (stack[l]) nxt = stack & ~(NUM_LVL'(1) << l);
    end
    if (push) nxt[push_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stack <= '0;
    else        stack <= nxt;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int ARR_MODS    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ext_pin,
  input  logic [1:0]          ext_edge_mode,
  input  logic                tmr0_ovf,
  input  logic                tmr1_ovf,
  input  logic                tmr2_ovf,
  input  logic                tmr2_ext,
  input  logic                ser_rx,
  input  logic                ser_tx,
  input  logic                arr_cnt,
  input  logic [ARR_MODS-1:0] arr_mod,
  input  logic [7:0]          ie_reg,
  input  logic [7:0]          iph_reg,
  input  logic [7:0]          ipl_reg,
  input  logic                irq_take,
  input  logic                irq_ret,
  output logic                irq_req,
  output logic [VEC_W-1:0]    irq_vec,
  output logic [NUM_SRC-1:0]  irq_ack,
  output logic [NUM_LVL-1:0]  lvl_active
);
  localparam int EXT_IDX [2] = '{0, 2};

  logic [1:0]         ext_flag;
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic               xfer;
  idx_t               win_idx;
  lvl_t               win_lvl;
  logic               unused_rsvd;

  assign unused_rsvd = iph_reg[7] ^ ipl_reg[7];

  for (genvar k = 0; k < 2; k++) begin : g_pin
    irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_pin[k]),
      .edge_mode (ext_edge_mode[k]),
      .clr       (grant[EXT_IDX[k]]),
      .flag      (ext_flag[k])
    );
  end

  assign raw = {arr_cnt | (|arr_mod),
                tmr2_ovf | tmr2_ext,
                ser_rx | ser_tx,
                tmr1_ovf,
                ext_flag[1],
                tmr0_ovf,
                ext_flag[0]};
  assign pend = raw & ie_reg[NUM_SRC-1:0];

  irq_select u_sel (
    .pend    (pend),
    .lvl_hi  (iph_reg[NUM_SRC-1:0]),
    .lvl_lo  (ipl_reg[NUM_SRC-1:0]),
    .glob_en (ie_reg[7]),
    .stack   (lvl_active),
    .req     (irq_req),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  assign xfer    = irq_req & irq_take;
  assign grant   = xfer ? (NUM_SRC'(1) << win_idx) : '0;
  assign irq_vec = src_vector(win_idx);

  irq_service_stack u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (xfer),
    .push_lvl (win_lvl),
    .pop      (irq_ret),
    .stack    (lvl_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_ack <= '0;
    else        irq_ack <= grant;
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ie_reg,
  input logic       irq_take,
  input logic       irq_ret,
  input logic       irq_req,
  input logic [23:0] irq_vec,
  input logic [6:0] irq_ack,
  input logic [3:0] lvl_active
);
  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));
  assert_ack_follows_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_take) |=> ($countones(irq_ack) == 1));
  assert_stack_marked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_take) |=> (lvl_active != 4'd0));
  assert_no_global_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_reg[7] |-> !irq_req);
  assert_top_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_active[3] |-> !irq_req);
  assert_vec_segment_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[23:16] == 8'hFF && irq_vec[2:0] == 3'b011));
  assert_ret_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_take && lvl_active != 4'd0) |=>
      ($countones(lvl_active) == $countones($past(lvl_active)) - 1));
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ie_reg     (ie_reg),
  .irq_take   (irq_take),
  .irq_ret    (irq_ret),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec),
  .irq_ack    (irq_ack),
  .lvl_active (lvl_active)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ext_pin = 2'b11;
  logic [1:0] ext_edge_mode = 2'b00;
  logic tmr0_ovf = 0, tmr1_ovf = 0, tmr2_ovf = 0, tmr2_ext = 0;
  logic ser_rx = 0, ser_tx = 0, arr_cnt = 0;
  logic [4:0] arr_mod = '0;
  logic [7:0] ie_reg = '0, iph_reg = '0, ipl_reg = '0;
  logic irq_take = 0, irq_ret = 0;
  logic irq_req;
  logic [23:0] irq_vec;
  logic [6:0] irq_ack;
  logic [3:0] lvl_active;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_arbiter dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    ext_pin = 2'b11; ext_edge_mode = 2'b00;
    {tmr0_ovf, tmr1_ovf, tmr2_ovf, tmr2_ext, ser_rx, ser_tx, arr_cnt} = '0;
    arr_mod = '0; ie_reg = '0; iph_reg = '0; ipl_reg = '0;
    idle(4);
  endtask

  task automatic take(output logic [6:0] ack_seen);
    irq_take = 1;
    @(negedge clk);
    irq_take = 0;
    ack_seen = irq_ack;
  endtask

  task automatic ret();
    irq_ret = 1;
    @(negedge clk);
    irq_ret = 0;
  endtask

  task automatic t_reset();
    chk("R1 req", 32'(irq_req), 0);
    chk("R1 ack", 32'(irq_ack), 0);
    chk("R1 lvl", 32'(lvl_active), 0);
  endtask

  task automatic t_enables();
    tmr0_ovf = 1; ie_reg = 8'h02; idle(1);
    chk("R2 global off", 32'(irq_req), 0);
    ie_reg = 8'h80; idle(1);
    chk("R3 source off", 32'(irq_req), 0);
    ie_reg = 8'h82; idle(1);
    chk("R3 source on", 32'(irq_req), 1);
    chk("R6 timer0 vec", 32'(irq_vec), 32'hFF000B);
    clear_all();
  endtask

  task automatic t_same_level();
    ie_reg = 8'hFF; tmr1_ovf = 1; ser_rx = 1; tmr2_ovf = 1; idle(1);
    chk("R5 timer1 first", 32'(irq_vec), 32'hFF001B);
    tmr1_ovf = 0; idle(1);
    chk("R5 serial next", 32'(irq_vec), 32'hFF0023);
    ser_rx = 0; idle(1);
    chk("R12 timer2 ovf", 32'(irq_vec), 32'hFF002B);
    tmr2_ovf = 0; tmr2_ext = 1; idle(1);
    chk("R12 timer2 ext", 32'(irq_vec), 32'hFF002B);
    tmr2_ext = 0; ser_tx = 1; idle(1);
    chk("R12 serial tx", 32'(irq_vec), 32'hFF0023);
    ser_tx = 0; arr_mod = 5'b00100; idle(1);
    chk("R12 array module", 32'(irq_vec), 32'hFF0033);
    chk("R12 array req", 32'(irq_req), 1);
    clear_all();
  endtask

  task automatic t_nesting();
    logic [6:0] a;
    ie_reg = 8'hCA; tmr0_ovf = 1; arr_cnt = 1; iph_reg = 8'h40; idle(1);
    chk("R4 level wins", 32'(irq_vec), 32'hFF0033);
    take(a);
    chk("R7 ack array", 32'(a), 32'h40);
    chk("R7 stack lvl2", 32'(lvl_active), 32'h4);
    chk("R8 lower held", 32'(irq_req), 0);
    idle(1);
    chk("R7 ack one cycle", 32'(irq_ack), 0);
    tmr1_ovf = 1; iph_reg = 8'h48; ipl_reg = 8'h08; idle(1);
    chk("R8 higher passes", 32'(irq_req), 1);
    chk("R6 timer1 vec", 32'(irq_vec), 32'hFF001B);
    take(a);
    chk("R7 ack timer1", 32'(a), 32'h08);
    tmr1_ovf = 0;
    chk("R7 stack lvl3", 32'(lvl_active), 32'hC);
    chk("R8 nested held", 32'(irq_req), 0);
    ret();
    chk("R9 pop top", 32'(lvl_active), 32'h4);
    ret();
    chk("R9 pop last", 32'(lvl_active), 32'h0);
    chk("R12 array still set", 32'(irq_req), 1);
    chk("R12 array vec", 32'(irq_vec), 32'hFF0033);
    clear_all();
  endtask

  task automatic t_edge();
    logic [6:0] a;
    ext_edge_mode = 2'b01; ie_reg = 8'h81; idle(2);
    ext_pin[0] = 0; idle(4);
    chk("R10 edge req", 32'(irq_req), 1);
    chk("R6 ext0 vec", 32'(irq_vec), 32'hFF0003);
    take(a);
    chk("R10 ack ext0", 32'(a), 32'h01);
    ret();
    idle(3);
    chk("R10 no retrigger", 32'(irq_req), 0);
    ext_pin[0] = 1; idle(4);
    ext_pin[0] = 0; idle(4);
    chk("R10 second edge", 32'(irq_req), 1);
    take(a); ret();
    clear_all();
  endtask

  task automatic t_level();
    logic [6:0] a;
    ie_reg = 8'h84; ext_pin[1] = 0; idle(3);
    chk("R11 level req", 32'(irq_req), 1);
    chk("R6 ext1 vec", 32'(irq_vec), 32'hFF0013);
    take(a);
    chk("R11 ack ext1", 32'(a), 32'h04);
    chk("R8 same level held", 32'(irq_req), 0);
    ret();
    chk("R11 not cleared", 32'(irq_req), 1);
    ext_pin[1] = 1; idle(3);
    chk("R11 follows pin", 32'(irq_req), 0);
    clear_all();
  endtask

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);
    t_reset();
    t_enables();
    t_same_level();
    t_nesting();
    t_edge();
    t_level();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule